// File: doc/BRIEF.md
# Charge-digitizer acquisition sequencer

This block runs the acquisition cycle of a multichannel charge-integrating digitizer. All channels share one gate input. While the gate is high the analog integrators collect charge. When the gate closes, the sequencer steps a channel multiplexer through half the channel count. On each step it starts two 12-bit converters together. Converter A digitizes the even channel of the pair and converter B the odd channel. Each step yields two results, which leave the block as single-cycle strobes carrying the channel index and the sample. After the last step a clear phase runs until the programmed dead time has passed. The busy output stays high from the gate leading edge until then.

A fast-clear input can abort the event. It takes effect only when the synchronized pulse stays high for a minimum number of cycles and qualifies inside a window. That window opens on the gate leading edge and lasts the number of cycles set on a register input. An aborted event emits no further results and holds busy high for a fixed lockout, counted from the synchronized fast-clear leading edge. A gate edge that arrives while busy is high does not start an event; it is counted instead. Every time value is a parameter in cycles of the single clock, with defaults sized for 100 MHz. The result strobe has no ready input, so the receiver must take every strobe as it arrives. Gate and fast clear pass through two-flop synchronizers.

Top module: `qgs_seq_top`

## Requirements
- R1: After reset, busy, the result strobe, both start strobes and the rejected-gate count are all zero.
- R2: When a gate is accepted (its synchronized level is high for G cycles), busy is high for exactly G + DEAD_CYC consecutive cycles, provided the event is not aborted.
- R3: Each event that is not aborted produces exactly NCH results, one per cycle-wide strobe. Channels appear in ascending order from 0 to NCH-1, and each result carries the 12-bit value present on the converter input at capture time.
- R4: Conversion is divided into NCH/2 slots of SLOT_CYC cycles. During slot k the multiplexer select equals k. Converter A then supplies channel 2k and converter B supplies channel 2k+1. Both start strobes are high together in the first cycle of each slot and low at all other times.
- R5: A fast clear whose synchronized level is high for fewer than MINW_CYC cycles has no effect: the event completes with all results and the normal busy length.
- R6: A qualified fast clear while the gate is open or during conversion, with fewer than win_len cycles elapsed since the gate was accepted, aborts the event. No further results follow. Busy is still high LOCK_CYC+1 clock edges after the fast-clear input rises, and low one edge later.
- R7: A qualified fast clear after the window has elapsed has no effect on the running conversion.
- R8: A gate leading edge while busy is high starts nothing and increments the saturating rejected-gate count by one. This also applies during the lockout.
- R9: Once the lockout has ended, a new gate is accepted and produces a complete event.
- R10: A fast clear while idle or during the clear phase leaves busy and the results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low reset |
| gate_in | input | 1 | Common gate, asynchronous |
| fclr_in | input | 1 | Fast-clear request, asynchronous |
| win_len | input | WIN_W | Abort window length in cycles from gate acceptance |
| mux_sel | output | SL_W (4) | Channel-pair select for the multiplexer |
| adc_start | output | 2 | Start strobes, bit 0 converter A, bit 1 converter B |
| adc_data_a | input | DATA_W (12) | Converter A result (even channels) |
| adc_data_b | input | DATA_W (12) | Converter B result (odd channels) |
| res_valid | output | 1 | One-cycle result strobe, no back-pressure |
| res_chan | output | CH_W (5) | Channel index of the result |
| res_data | output | DATA_W (12) | Sample of the result |
| busy | output | 1 | Dead-time indicator |
| gate_rejects | output | RJ_W (16) | Saturating count of gates refused while busy |

## Verification
The bench builds the block with 8 channels, 4-cycle slots, a dead time of 24 cycles, a 3-cycle minimum fast-clear width and a 12-cycle lockout. With these values a whole event, an abort and the following lockout each fit in a few dozen cycles. The bench can then count busy cycles exactly, and it can place fast clears in the gate phase, in the conversion phase, after the window and in the clear phase. Its converter model returns a value computed from the channel index, so any swap between the channel index and the converter value shows up as a data mismatch.

// File: rtl/qgs_pkg.sv
package qgs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_GATE  = 3'd1,
    ST_CONV  = 3'd2,
    ST_CLEAR = 3'd3,
    ST_LOCK  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/qgs_sync.sv
module qgs_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= 1'b0;
      sync_out <= 1'b0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/qgs_width_qual.sv
module qgs_width_qual #(
  parameter int MINW_CYC = 3,
  localparam int CW = $clog2(MINW_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic qual
);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else if (!level) run_q <= '0;
    else if (run_q != CW'(MINW_CYC)) run_q <= run_q + 1'b1;
  end

  assign qual = level && (run_q == CW'(MINW_CYC - 1));

  // R5
  qual_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    qual && (MINW_CYC > 1) |-> $past(level));
endmodule

// File: rtl/qgs_conv_seq.sv
module qgs_conv_seq #(
  parameter int NCH      = 32,
  parameter int DATA_W   = 12,
  parameter int SLOT_CYC = 36,
  localparam int CH_W  = $clog2(NCH),
  localparam int SL_W  = CH_W - 1,
  localparam int NSLOT = NCH / 2,
  localparam int CY_W  = $clog2(SLOT_CYC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              kill,
  output logic              done,
  output logic [SL_W-1:0]   mux_sel,
  output logic [1:0]        adc_start,
  input  logic [DATA_W-1:0] adc_data_a,
  input  logic [DATA_W-1:0] adc_data_b,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [DATA_W-1:0] res_data
);
  logic              active_q;
  logic [SL_W-1:0]   slot_q;
  logic [CY_W-1:0]   cyc_q;
  logic              pend_q;
  logic [DATA_W-1:0] hold_b_q;
  logic              slot_end;

  assign slot_end  = active_q && (cyc_q == CY_W'(SLOT_CYC - 1));
  assign done      = slot_end && (slot_q == SL_W'(NSLOT - 1));
  assign mux_sel   = slot_q;
  assign adc_start = (active_q && cyc_q == '0) ? 2'b11 : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      cyc_q    <= '0;
    end else if (kill) begin
      active_q <= 1'b0;
      slot_q   <= '0;
      cyc_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      slot_q   <= '0;
      cyc_q    <= '0;
    end else if (active_q) begin
      if (slot_end) begin
        cyc_q    <= '0;
        slot_q   <= slot_q + 1'b1;
        active_q <= !done;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_chan  <= '0;
      res_data  <= '0;
      pend_q    <= 1'b0;
      hold_b_q  <= '0;
    end else if (kill) begin
      res_valid <= 1'b0;
      pend_q    <= 1'b0;
    end else if (slot_end) begin
      res_valid <= 1'b1;
      res_chan  <= {slot_q, 1'b0};
      res_data  <= adc_data_a;
      hold_b_q  <= adc_data_b;
      pend_q    <= 1'b1;
    end else if (pend_q) begin
      res_valid <= 1'b1;
      res_chan  <= res_chan + 1'b1;
      res_data  <= hold_b_q;
      pend_q    <= 1'b0;
    end else begin
      res_valid <= 1'b0;
    end
  end

  // R4
  start_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_start == 2'b00) || (adc_start == 2'b11));
  // R4
  sel_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && (cyc_q != '0) |-> $stable(mux_sel));
  // R3
  chan_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && $past(res_valid) |-> res_chan == $past(res_chan) + 1'b1);
endmodule

// File: rtl/qgs_seq_top.sv
module qgs_seq_top
  import qgs_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int DATA_W   = 12,
  parameter int SLOT_CYC = 36,
  parameter int DEAD_CYC = 690,
  parameter int MINW_CYC = 3,
  parameter int LOCK_CYC = 60,
  parameter int WIN_W    = 16,
  parameter int RJ_W     = 16,
  localparam int CH_W = $clog2(NCH),
  localparam int SL_W = CH_W - 1,
  localparam int DC_W = $clog2(DEAD_CYC + 1),
  localparam int LC_W = $clog2(LOCK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_in,
  input  logic              fclr_in,
  input  logic [WIN_W-1:0]  win_len,
  output logic [SL_W-1:0]   mux_sel,
  output logic [1:0]        adc_start,
  input  logic [DATA_W-1:0] adc_data_a,
  input  logic [DATA_W-1:0] adc_data_b,
  output logic              res_valid,
  output logic [CH_W-1:0]   res_chan,
  output logic [DATA_W-1:0] res_data,
  output logic              busy,
  output logic [RJ_W-1:0]   gate_rejects
);
  seq_state_e       st_q, st_nxt;
  logic             gate_s, gate_d, fclr_s;
  logic             g_rise, g_fall, fc_qual, in_win, abort, go, conv_done;
  logic [WIN_W-1:0] win_q;
  logic [DC_W-1:0]  dead_q;
  logic [LC_W-1:0]  lock_q;

  qgs_sync u_gsync (.clk(clk), .rst_n(rst_n), .async_in(gate_in), .sync_out(gate_s));
  qgs_sync u_fsync (.clk(clk), .rst_n(rst_n), .async_in(fclr_in), .sync_out(fclr_s));

  qgs_width_qual #(.MINW_CYC(MINW_CYC)) u_fqual (
    .clk(clk), .rst_n(rst_n), .level(fclr_s), .qual(fc_qual));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_d <= 1'b0;
    else        gate_d <= gate_s;
  end

  assign g_rise = gate_s && !gate_d;
  assign g_fall = !gate_s && gate_d;
  assign in_win = win_q < win_len;
  assign abort  = fc_qual && in_win && (st_q == ST_GATE || st_q == ST_CONV);
  assign go     = (st_q == ST_GATE) && (st_nxt == ST_CONV);

  always_comb begin
    st_nxt = st_q;
    unique case (st_q)
      ST_IDLE:  if (g_rise) st_nxt = ST_GATE;
      ST_GATE:  if (abort) st_nxt = ST_LOCK;
                else if (g_fall) st_nxt = ST_CONV;
      ST_CONV:  if (abort) st_nxt = ST_LOCK;
                else if (conv_done) st_nxt = ST_CLEAR;
      ST_CLEAR: if (dead_q == DC_W'(DEAD_CYC - 1)) st_nxt = ST_IDLE;
      ST_LOCK:  if (lock_q == '0) st_nxt = ST_IDLE;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      busy <= 1'b0;
    end else begin
      st_q <= st_nxt;
      busy <= (st_nxt != ST_IDLE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      dead_q <= '0;
      lock_q <= '0;
    end else begin
      if (st_q == ST_IDLE) win_q <= '0;
      else if (win_q != '1) win_q <= win_q + 1'b1;
      if (go) dead_q <= '0;
      else if (st_q == ST_CONV || st_q == ST_CLEAR) dead_q <= dead_q + 1'b1;
      if (abort) lock_q <= LC_W'(LOCK_CYC - MINW_CYC - 1);
      else if (st_q == ST_LOCK && lock_q != '0) lock_q <= lock_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_rejects <= '0;
    else if (g_rise && st_q != ST_IDLE && gate_rejects != '1)
      gate_rejects <= gate_rejects + 1'b1;
  end

  qgs_conv_seq #(.NCH(NCH), .DATA_W(DATA_W), .SLOT_CYC(SLOT_CYC)) u_conv (
    .clk(clk), .rst_n(rst_n), .go(go), .kill(abort), .done(conv_done),
    .mux_sel(mux_sel), .adc_start(adc_start),
    .adc_data_a(adc_data_a), .adc_data_b(adc_data_b),
    .res_valid(res_valid), .res_chan(res_chan), .res_data(res_data));

  // R2
  valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> busy);
  // R6
  abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !res_valid);
  // R6
  lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == ST_LOCK |-> busy);
  // R8
  rej_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> gate_rejects >= $past(gate_rejects));
endmodule

// File: tb/qgs_seq_top_tb.sv
module qgs_seq_top_tb_top;
  localparam int NCH = 8, SLOT = 4, DEAD = 24, MINW = 3, LOCK = 12;

  logic        clk = 1'b0, rst_n = 1'b0, gate_in = 1'b0, fclr_in = 1'b0;
  logic [7:0]  win_len = 8'd200;
  logic [1:0]  mux_sel;
  logic [1:0]  adc_start;
  logic [11:0] adc_data_a, adc_data_b;
  logic        res_valid, busy;
  logic [2:0]  res_chan;
  logic [11:0] res_data;
  logic [15:0] gate_rejects;

  int checks = 0, errors = 0;
  bit mon_en = 1'b0, done = 1'b0;
  int vcnt, bad_order, bad_data, busy_cnt, start_cnt, bad_sel;

  always #4 clk = ~clk;

  function automatic logic [11:0] ch_val(int ch);
    return 12'((ch * 291 + 17) & 12'hFFF);
  endfunction

  assign adc_data_a = ch_val(2 * int'(mux_sel));
  assign adc_data_b = ch_val(2 * int'(mux_sel) + 1);

  qgs_seq_top #(.NCH(NCH), .DATA_W(12), .SLOT_CYC(SLOT), .DEAD_CYC(DEAD),
                .MINW_CYC(MINW), .LOCK_CYC(LOCK), .WIN_W(8), .RJ_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .fclr_in(fclr_in),
    .win_len(win_len), .mux_sel(mux_sel), .adc_start(adc_start),
    .adc_data_a(adc_data_a), .adc_data_b(adc_data_b), .res_valid(res_valid),
    .res_chan(res_chan), .res_data(res_data), .busy(busy),
    .gate_rejects(gate_rejects));

  always @(negedge clk) if (mon_en) begin
    if (busy) busy_cnt++;
    if (adc_start == 2'b11) begin
      if (int'(mux_sel) != start_cnt) bad_sel++;
      start_cnt++;
    end else if (adc_start != 2'b00) bad_sel++;
    if (res_valid) begin
      if (int'(res_chan) != vcnt) bad_order++;
      if (res_data != ch_val(int'(res_chan))) bad_data++;
      vcnt++;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mon_start();
    @(negedge clk);
    vcnt = 0; bad_order = 0; bad_data = 0; busy_cnt = 0; start_cnt = 0; bad_sel = 0;
    mon_en = 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    mon_en = 1'b0;
  endtask

  task automatic full_event_checks(string req, int g);
    check({req, " result count"}, vcnt, NCH);
    check({req, " order"}, bad_order, 0);
    check({req, " data"}, bad_data, 0);
    check({req, " busy cycles"}, busy_cnt, g + DEAD);
  endtask

  task automatic t_reset();
    check("R1 busy", int'(busy), 0);
    check("R1 valid", int'(res_valid), 0);
    check("R1 start", int'(adc_start), 0);
    check("R1 rejects", int'(gate_rejects), 0);
  endtask

  task automatic t_normal();
    win_len = 8'd200;
    mon_start();
    gate_in = 1'b1; repeat (5) @(negedge clk); gate_in = 1'b0;
    settle();
    full_event_checks("R2 R3", 5);
    check("R4 start strobes", start_cnt, NCH / 2);
    check("R4 select per slot", bad_sel, 0);
  endtask

  task automatic t_reject_busy();
    int r0 = int'(gate_rejects);
    mon_start();
    gate_in = 1'b1; repeat (4) @(negedge clk); gate_in = 1'b0;
    repeat (8) @(negedge clk);
    gate_in = 1'b1; repeat (2) @(negedge clk); gate_in = 1'b0;
    settle();
    full_event_checks("R8 busy", 4);
    check("R8 reject count", int'(gate_rejects), r0 + 1);
  endtask

  task automatic t_short_fc();
    win_len = 8'd200;
    mon_start();
    gate_in = 1'b1; repeat (2) @(negedge clk);
    fclr_in = 1'b1; repeat (MINW - 1) @(negedge clk); fclr_in = 1'b0;
    repeat (2) @(negedge clk); gate_in = 1'b0;
    settle();
    full_event_checks("R5", 2 + MINW - 1 + 2);
  endtask

  task automatic t_abort_conv();
    win_len = 8'd200;
    mon_start();
    gate_in = 1'b1; repeat (4) @(negedge clk); gate_in = 1'b0;
    while (vcnt < 2) @(negedge clk);
    fclr_in = 1'b1;
    for (int n = 1; n <= LOCK + 2; n++) begin
      @(posedge clk); @(negedge clk);
      if (n == 4) fclr_in = 1'b0;
      if (n == LOCK + 1) check("R6 busy held in lockout", int'(busy), 1);
      if (n == LOCK + 2) check("R6 busy falls after lockout", int'(busy), 0);
    end
    settle();
    check("R6 abort cuts results", int'(vcnt < NCH && vcnt >= 2), 1);
    check("R6 partial order", bad_order, 0);
  endtask

  task automatic t_abort_gate_lock();
    int r0 = int'(gate_rejects);
    win_len = 8'd200;
    mon_start();
    gate_in = 1'b1; repeat (2) @(negedge clk);
    fclr_in = 1'b1; repeat (4) @(negedge clk); fclr_in = 1'b0;
    @(negedge clk); gate_in = 1'b0;
    repeat (2) @(negedge clk); gate_in = 1'b1;
    repeat (2) @(negedge clk); gate_in = 1'b0;
    settle();
    check("R6 no results after abort in gate", vcnt, 0);
    check("R8 gate in lockout rejected", int'(gate_rejects), r0 + 1);
    mon_start();
    gate_in = 1'b1; repeat (3) @(negedge clk); gate_in = 1'b0;
    settle();
    full_event_checks("R9", 3);
  endtask

  task automatic t_outside();
    win_len = 8'd3;
    mon_start();
    gate_in = 1'b1; repeat (8) @(negedge clk);
    fclr_in = 1'b1; repeat (4) @(negedge clk); fclr_in = 1'b0;
    repeat (4) @(negedge clk); gate_in = 1'b0;
    settle();
    full_event_checks("R7", 16);
    win_len = 8'd200;
  endtask

  task automatic t_fc_idle_clear();
    win_len = 8'd200;
    mon_start();
    fclr_in = 1'b1; repeat (5) @(negedge clk); fclr_in = 1'b0;
    repeat (10) @(negedge clk);
    check("R10 idle fast clear keeps busy low", busy_cnt, 0);
    mon_en = 1'b0;
    mon_start();
    gate_in = 1'b1; repeat (4) @(negedge clk); gate_in = 1'b0;
    while (vcnt < NCH) @(negedge clk);
    fclr_in = 1'b1; repeat (4) @(negedge clk); fclr_in = 1'b0;
    settle();
    full_event_checks("R10 clear phase", 4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_normal();
    t_reject_busy();
    t_short_fc();
    t_abort_conv();
    t_abort_gate_lock();
    t_outside();
    t_fc_idle_clear();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule